// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a serial bit stream and samples one bit on each clock edge where the valid strobe is high. It raises a single detect flag whenever the four most recent accepted bits spell either 1101 or 1011. The earliest accepted bit counts as the leftmost bit of each pattern. Matches may overlap, so the tail of one match can serve as the head of the next.

One eight-state Moore machine tracks both patterns. Two separate recognisers joined by an OR are not used. The detect flag is decoded from the state register alone. It therefore rises on the clock edge that accepts the final bit of a pattern and holds while the strobe stays low.

Top module: `dual_seq_detector`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the machine returns to the no-history state, so `hit` reads 0 after that edge. No bit accepted before the reset can contribute to a later match.
- R2: When the last four accepted bits, oldest first, are 1,1,0,1, `hit` is 1 after the edge that accepted the final bit.
- R3: When the last four accepted bits, oldest first, are 1,0,1,1, `hit` is 1 after the edge that accepted the final bit.
- R4: Overlapping matches are all reported. The stream 1101101 gives `hit`=1 after the 4th, 5th and 7th accepted bits.
- R5: When 1 is accepted while the 1101 match is being shown, `hit` stays 1 for the next accepted bit as well, because 1011 has just completed.
- R6: On edges where `bit_vld` is 0, `bit_in` is ignored. The state and `hit` are unchanged, and the stream continues as if those cycles had not occurred.
- R7: After every accepted bit, `hit` is 0 unless the last four accepted bits are exactly 1101 or 1011. In particular, `hit` is 0 after any accepted 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High when `bit_in` carries a bit to accept |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | High while the last four accepted bits form 1101 or 1011 |

## Verification
The bench keeps its own four-bit history of accepted bits and compares `hit` against it after every edge. It covers random streams with a gappy strobe and the three directed streams 010101011, 111111101 and 11011011.

The chained case 11011 targets a machine that, after a 1101 match, falls back to a partial-match state instead of the 1011-complete state; such a machine would drop the second pulse. The run 1101101 targets a design without overlap, which would miss the later matches. Gaps in the strobe inside a pattern catch a design that shifts in the bits it should ignore. A reset applied in the middle of a pattern catches history that survives the reset.

// File: rtl/dual_seq_detector.sv
module dual_seq_detector (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit
);

  // Codes picked so that most frequent moves flip one bit
  typedef enum logic [2:0] {
    IDLE  = 3'b000,
    G1    = 3'b001,
    G11   = 3'b011,
    G10   = 3'b101,
    G101  = 3'b111,
    G110  = 3'b100,
    M1011 = 3'b110,
    M1101 = 3'b010
  } st_t;

  st_t st, st_nx;

  always_comb begin
    st_nx = st;
    if (bit_vld) begin
      case (st)
        IDLE:    st_nx = bit_in ? G1    : IDLE;
        G1:      st_nx = bit_in ? G11   : G10;
        G10:     st_nx = bit_in ? G101  : IDLE;
        G101:    st_nx = bit_in ? M1011 : G10;
        M1011:   st_nx = bit_in ? G11   : G110;
        G11:     st_nx = bit_in ? G11   : G110;
        G110:    st_nx = bit_in ? M1101 : IDLE;
        M1101:   st_nx = bit_in ? M1011 : G10;
        default: st_nx = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= IDLE;
    else     st <= st_nx;
  end

  assign hit = (st == M1011) || (st == M1101);

endmodule

// File: rtl/dual_seq_detector_chk.sv
module dual_seq_detector_chk (
  input logic clk,
  input logic rst,
  input logic bit_vld,
  input logic bit_in,
  input logic hit
);

  logic [3:0] seen;

  always_ff @(posedge clk) begin
    if (rst)          seen <= 4'b0000;
    else if (bit_vld) seen <= {seen[2:0], bit_in};
  end

  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !hit);

  // R2 R3 R4 R7: flag tracks the last four accepted bits
  assert_match_R2: assert property (@(posedge clk) disable iff (rst)
    hit == ((seen == 4'b1101) || (seen == 4'b1011)));

  assert_chain_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_in && seen == 4'b1101) |=> hit);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(hit));

  assert_zero_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !bit_in) |=> !hit);

endmodule

bind dual_seq_detector dual_seq_detector_chk u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .hit(hit)
);

// File: tb/tb_dual_seq_detector.sv
module tb_dual_seq_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic hit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [3:0] hist = 4'b0000;

  always #2 clk = ~clk;

  dual_seq_detector dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .hit(hit)
  );

  function automatic logic want(input logic [3:0] h);
    return (h == 4'b1101) || (h == 4'b1011);
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (hit !== exp) begin
      failures++;
      $display("FAIL %s hit=%b expected=%b t=%0t", tag, hit, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic b);
    bit_vld = v;
    bit_in = b;
    @(posedge clk);
    #1;
    if (v) hist = {hist[2:0], b};
    check(tag, want(hist));
  endtask

  task automatic feed(input string tag, input string s);
    for (int i = 0; i < s.len(); i++) step(tag, 1'b1, s[i] == "1");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_vld = 1'b0;
    @(posedge clk);
    #1;
    hist = 4'b0000;
    check("R1", 1'b0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1", 1'b0);
    rst = 1'b0;

    // R2 single pattern, explicit expectations
    feed("R2", "110");
    step("R2", 1'b1, 1'b1);
    check("R2", 1'b1);
    do_reset();

    // R3 single pattern
    feed("R3", "101");
    step("R3", 1'b1, 1'b1);
    check("R3", 1'b1);
    do_reset();

    // R4 overlapping run: hits after bits 4, 5 and 7
    feed("R4", "1101101");
    check("R4", 1'b1);
    do_reset();

    // R5 chained: 1101 then 1 keeps hit high
    feed("R5", "1101");
    check("R5", 1'b1);
    step("R5", 1'b1, 1'b1);
    check("R5", 1'b1);
    step("R5", 1'b1, 1'b1);
    check("R5", 1'b0);
    do_reset();

    // R6 gaps inside a pattern, and hold while hit is high
    feed("R6", "11");
    step("R6", 1'b0, 1'b1);
    step("R6", 1'b0, 1'b1);
    step("R6", 1'b1, 1'b0);
    step("R6", 1'b0, 1'b0);
    step("R6", 1'b1, 1'b1);
    check("R6", 1'b1);
    for (int i = 0; i < 4; i++) begin
      step("R6", 1'b0, i[0]);
      check("R6", 1'b1);
    end
    do_reset();

    // R1 mid-pattern reset discards history
    feed("R1", "110");
    do_reset();
    step("R1", 1'b1, 1'b1);
    check("R1", 1'b0);
    do_reset();

    // R7 non-matching streams
    feed("R7", "0000111110011001");
    feed("R7", "1101");
    step("R7", 1'b1, 1'b0);
    check("R7", 1'b0);
    do_reset();

    // Directed streams
    feed("R3", "010101011");
    do_reset();
    feed("R2", "111111101");
    do_reset();
    feed("R4", "11011011");
    do_reset();

    // Random streams with a gappy strobe
    for (int i = 0; i < 3000; i++) begin
      step("R7", ($urandom % 4) != 0, $urandom % 2);
      if (($urandom % 500) == 0) do_reset();
    end

    finish_run();
  end

endmodule